// File: doc/BRIEF.md
# Dual Recursive Convolutional Encoder with Tail Packing

This block encodes one block of K information bits with two identical 8-state recursive systematic convolutional encoders. The first encoder sees the information bits in natural order. The second sees the already-interleaved copy, which arrives on a second input lane beside the first. Each input bit produces three output bits: the systematic bit, the first encoder's parity and the second encoder's parity. The parameter `LANES` sets how many information bits are taken and emitted per clock: 1, 4 or 8. K must be a multiple of `LANES`.

After the last data word, both encoders are driven back to the all-zero state in three steps each. The resulting twelve tail bits are sent in a fixed interleaved order. Serial builds send them over four words. The 4- and 8-lane builds pack them into one final word.

Input and output both use a valid/ready handshake with start and end markers. A single output register stalls under back-pressure without dropping or repeating words.

Top module: `rsc_pair_packer`

## Requirements
- R1: Input word i carries bit i·LANES+l on lane l of `in_sys` (and of `in_ilv`). With LANES=1 each data output word is 3 bits: bit 0 is the systematic bit, bit 1 the first encoder's parity and bit 2 the second encoder's parity.
- R2: With LANES of 4 or 8, a data output word holds three LANES-bit fields. Bits [LANES-1:0] carry the systematic bits, the next field up carries the first parity and the top field carries the second parity. Within a field, bit l belongs to input lane l.
- R3: Each encoder has feedback polynomial 1+D²+D³ and feedforward polynomial 1+D+D³, so parity = w⊕d1⊕d3 with w = u⊕d2⊕d3. The first encoder runs on `in_sys` and the second on `in_ilv`. Both start from state zero on the word flagged `in_sop`, and state carries across words within a block.
- R4: With LANES=1, four tail words follow the data. Each encoder's tail steps use input u = d2⊕d3, which gives the sequence x0,z0,x1,z1,x2,z2. Words 0 and 1 carry the first encoder's sequence elements 0–2 and 3–5 on bits 0–2. Words 2 and 3 do the same for the second encoder.
- R5: With LANES of 4 or 8, one tail word follows the data. In field f (f = 0, 1, 2), bit c of the low nibble equals bit f of serial tail word c. With LANES=8, bits 4–7 of every field are zero in that word.
- R6: While `out_valid` is high and `out_ready` is low, the output word and its markers stay unchanged on the next cycle. Every expected word is delivered exactly once, in order.
- R7: Once the word flagged `in_eop` is accepted, `in_ready` stays low until the cycle in which the final tail word is handed over.
- R8: `out_sop` is set only on the first data word of a block, and `out_eop` only on its last tail word.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts an input word this cycle |
| in_sop | input | 1 | Input word is the first of a block |
| in_eop | input | 1 | Input word is the last of a block |
| in_sys | input | LANES | Information bits, lowest index in lane 0 |
| in_ilv | input | LANES | Interleaved information bits for the second encoder |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_sop | output | 1 | First data word of a block |
| out_eop | output | 1 | Last tail word of a block |
| out_data | output | 3*LANES | Packed systematic, parity and tail bits |

## Verification
The bench builds three copies of the block, with LANES set to 1, 4 and 8. Together they cover the four-word serial tail and both packed tail layouts, including the zeroed upper nibbles of the 8-lane tail. Each copy runs blocks of one, two, three and five words. The data patterns are all ones, alternating bits, pseudo-random bits and a single trailing one, so the tails leave nonzero states. Downstream ready is held high, toggled often or asserted rarely, which exercises stalls on data and tail words and the closing of the input during the tail.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
package rsc_pkg;
    // bit 0 = one-cycle delay element, bit 2 = three-cycle delay element
    typedef logic [2:0] trellis_t;

    typedef enum logic {
        PH_DATA = 1'b0,
        PH_TAIL = 1'b1
    } phase_e;
endpackage

// File: rtl/rsc_lane_enc.sv
`timescale 1ns/1ps
module rsc_lane_enc
    import rsc_pkg::*;
#(
    parameter int LANES = 1
) (
    input  trellis_t           state_in,
    input  logic [LANES-1:0]   bits_in,
    output trellis_t           state_out,
    output logic [LANES-1:0]   parity,
    output logic [5:0]         tail_seq
);
    // Data path: LANES trellis steps chained in one cycle.
    always_comb begin : data_walk
        trellis_t s;
        logic     fb;
        logic     w;
        s      = state_in;
        parity = '0;
        for (int l = 0; l < LANES; l++) begin
            fb        = s[1] ^ s[2];
            w         = bits_in[l] ^ fb;
            parity[l] = w ^ s[0] ^ s[2];
            s         = {s[1], s[0], w};
        end
        state_out = s;
    end

    // Termination: input equals feedback, so zero is shifted in.
    always_comb begin : tail_walk
        trellis_t t;
        t        = state_in;
        tail_seq = '0;
        for (int n = 0; n < 3; n++) begin
            tail_seq[2*n]   = t[1] ^ t[2];
            tail_seq[2*n+1] = t[0] ^ t[2];
            t               = {t[1], t[0], 1'b0};
        end
    end
endmodule

// File: rtl/rsc_tail_mux.sv
`timescale 1ns/1ps
module rsc_tail_mux #(
    parameter int LANES = 1,
    localparam int OW   = 3 * LANES
) (
    input  logic [5:0]    seq_a,
    input  logic [5:0]    seq_b,
    input  logic [1:0]    slot,
    output logic [OW-1:0] word
);
    generate
        if (LANES == 1) begin : g_serial
            logic [5:0] src;
            always_comb begin
                src  = slot[1] ? seq_b : seq_a;
                word = slot[0] ? src[5:3] : src[2:0];
            end
        end else begin : g_packed
            // nibble bit c of field f equals bit f of serial tail word c
            always_comb begin
                word = '0;
                if (slot == 2'd0) begin
                    for (int f = 0; f < 3; f++) begin
                        word[f*LANES +: 4] = {seq_b[f+3], seq_b[f], seq_a[f+3], seq_a[f]};
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rsc_pair_packer.sv
`timescale 1ns/1ps
module rsc_pair_packer
    import rsc_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [LANES-1:0]   in_sys,
    input  logic [LANES-1:0]   in_ilv,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_sop,
    output logic               out_eop,
    output logic [3*LANES-1:0] out_data
);
    localparam int OW         = 3 * LANES;
    localparam int TAIL_WORDS = (LANES == 1) ? 4 : 1;
    localparam logic [1:0] LAST_SLOT = 2'(TAIL_WORDS - 1);

    generate
        if (!(LANES == 1 || LANES == 4 || LANES == 8)) begin : g_bad_lanes
            $error("LANES must be 1, 4 or 8");
        end
    endgenerate

    typedef struct packed {
        logic          valid;
        logic          sop;
        logic          eop;
        logic [OW-1:0] data;
        phase_e        phase;
        logic [1:0]    slot;
        trellis_t      st_a;
        trellis_t      st_b;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             load, take;
    trellis_t         base_a, base_b, next_a, next_b;
    logic [LANES-1:0] par_a, par_b;
    logic [5:0]       seq_a, seq_b;
    logic [OW-1:0]    tail_word;

    always_comb begin
        load     = !ctl_q.valid || out_ready;
        in_ready = load && (ctl_q.phase == PH_DATA);
        take     = in_valid && in_ready;
        base_a   = (take && in_sop) ? trellis_t'('0) : ctl_q.st_a;
        base_b   = (take && in_sop) ? trellis_t'('0) : ctl_q.st_b;
    end

    rsc_lane_enc #(.LANES(LANES)) u_enc_a (
        .state_in (base_a),
        .bits_in  (in_sys),
        .state_out(next_a),
        .parity   (par_a),
        .tail_seq (seq_a)
    );

    rsc_lane_enc #(.LANES(LANES)) u_enc_b (
        .state_in (base_b),
        .bits_in  (in_ilv),
        .state_out(next_b),
        .parity   (par_b),
        .tail_seq (seq_b)
    );

    rsc_tail_mux #(.LANES(LANES)) u_tail (
        .seq_a(seq_a),
        .seq_b(seq_b),
        .slot (ctl_q.slot),
        .word (tail_word)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (load) begin
            ctl_d.valid = 1'b0;
            ctl_d.sop   = 1'b0;
            ctl_d.eop   = 1'b0;
        end
        if (take) begin
            ctl_d.valid = 1'b1;
            ctl_d.sop   = in_sop;
            ctl_d.data  = {par_b, par_a, in_sys};
            ctl_d.st_a  = next_a;
            ctl_d.st_b  = next_b;
            if (in_eop) begin
                ctl_d.phase = PH_TAIL;
                ctl_d.slot  = 2'd0;
            end
        end else if (load && ctl_q.phase == PH_TAIL) begin
            ctl_d.valid = 1'b1;
            ctl_d.data  = tail_word;
            if (ctl_q.slot == LAST_SLOT) begin
                ctl_d.eop   = 1'b1;
                ctl_d.phase = PH_DATA;
                ctl_d.slot  = 2'd0;
            end else begin
                ctl_d.slot  = ctl_q.slot + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign out_valid = ctl_q.valid;
    assign out_sop   = ctl_q.sop;
    assign out_eop   = ctl_q.eop;
    assign out_data  = ctl_q.data;
endmodule

// File: rtl/rsc_pair_packer_chk.sv
`timescale 1ns/1ps
module rsc_pair_packer_chk #(
    parameter int LANES = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               in_eop,
    input logic               out_valid,
    input logic               out_ready,
    input logic               out_sop,
    input logic               out_eop,
    input logic [3*LANES-1:0] out_data
);
    logic in_tail_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                                in_tail_q <= 1'b0;
        else if (in_valid && in_ready && in_eop)   in_tail_q <= 1'b1;
        else if (out_valid && out_ready && out_eop) in_tail_q <= 1'b0;
    end

    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

    a_r7_input_closed: assert property (@(posedge clk) disable iff (!rst_n)
        in_tail_q && !(out_valid && out_ready && out_eop) |-> !in_ready);

    a_r8_eop_in_tail_only: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eop |-> in_tail_q);

    a_r8_markers_apart: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sop && out_eop));

    generate
        if (LANES == 8) begin : g_wide
            a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && out_eop |-> (out_data[7:4] == 4'd0) && (out_data[15:12] == 4'd0)
                                         && (out_data[23:20] == 4'd0));
        end
    endgenerate
endmodule

bind rsc_pair_packer rsc_pair_packer_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/rsc_pair_packer_tb.sv
`timescale 1ns/1ps
module rsc_lane_bench #(
    parameter int P = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic done,
    output int   n_chk,
    output int   n_bad
);
    localparam int OW = 3 * P;

    logic          in_valid, in_ready, in_sop, in_eop;
    logic          out_valid, out_ready, out_sop, out_eop;
    logic [P-1:0]  in_sys, in_ilv;
    logic [OW-1:0] out_data;

    rsc_pair_packer #(.LANES(P)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
        .in_sys(in_sys), .in_ilv(in_ilv),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
    );

    int chk = 0;
    int bad = 0;
    assign n_chk = chk;
    assign n_bad = bad;

    logic [OW+2:0] expq[$];       // {is_tail, eop, sop, data}
    logic          tail_pending = 1'b0;
    int            rdy_mode = 0;
    logic [15:0]   lfsr = 16'hACE1;
    logic          xa[64];
    logic          ya[64];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s P=%0d actual=%h expected=%h", req, P, act, exp);
        end
    endtask

    // delay-line view: d1 newest, d3 oldest
    task automatic model(input int K);
        logic a1, a2, a3, b1, b2, b3, wa, wb, za, zb;
        logic [5:0]    sa, sb;
        logic [OW-1:0] word;
        a1 = 0; a2 = 0; a3 = 0; b1 = 0; b2 = 0; b3 = 0;
        for (int w = 0; w < K / P; w++) begin
            word = '0;
            for (int l = 0; l < P; l++) begin
                wa = xa[w*P+l] ^ a2 ^ a3;  za = wa ^ a1 ^ a3;
                a3 = a2; a2 = a1; a1 = wa;
                wb = ya[w*P+l] ^ b2 ^ b3;  zb = wb ^ b1 ^ b3;
                b3 = b2; b2 = b1; b1 = wb;
                word[l]       = xa[w*P+l];
                word[P+l]     = za;
                word[2*P+l]   = zb;
            end
            expq.push_back({1'b0, 1'b0, (w == 0), word});
        end
        for (int n = 0; n < 3; n++) begin
            sa[2*n] = a2 ^ a3;  sa[2*n+1] = a1 ^ a3;
            a3 = a2; a2 = a1; a1 = 1'b0;
            sb[2*n] = b2 ^ b3;  sb[2*n+1] = b1 ^ b3;
            b3 = b2; b2 = b1; b1 = 1'b0;
        end
        if (P == 1) begin
            for (int c = 0; c < 4; c++) begin
                logic [5:0] src;
                int         off;
                src  = (c < 2) ? sa : sb;
                off  = (c % 2) * 3;
                word = '0;
                for (int f = 0; f < 3; f++) word[f] = src[off+f];
                expq.push_back({1'b1, (c == 3), 1'b0, word});
            end
        end else begin
            word = '0;
            for (int f = 0; f < 3; f++) begin
                word[f*P+0] = sa[f];
                word[f*P+1] = sa[f+3];
                word[f*P+2] = sb[f];
                word[f*P+3] = sb[f+3];
            end
            expq.push_back({1'b1, 1'b1, 1'b0, word});
        end
    endtask

    task automatic send_block(input int K, input int pat, input int mode);
        int seed;
        seed     = K * 31 + pat * 7 + P;
        rdy_mode = mode;
        for (int i = 0; i < K; i++) begin
            seed = seed * 1103515245 + 12345;
            case (pat)
                0:       xa[i] = 1'b1;
                1:       xa[i] = logic'(i % 2);
                2:       xa[i] = seed[16];
                default: xa[i] = (i == K - 1);
            endcase
        end
        for (int i = 0; i < K; i++)
            ya[i] = xa[(i * 5 + 2) % K] ^ ((pat == 2) && (i % 3 == 0));
        model(K);
        for (int w = 0; w < K / P; w++) begin
            @(negedge clk); #0.2;
            in_valid = 1'b1;
            in_sop   = (w == 0);
            in_eop   = (w == K / P - 1);
            for (int l = 0; l < P; l++) begin
                in_sys[l] = xa[w*P+l];
                in_ilv[l] = ya[w*P+l];
            end
            while (!in_ready) begin
                @(negedge clk); #0.2;
            end
            @(posedge clk);
            if (in_eop) tail_pending = 1'b1;
        end
        @(negedge clk); #0.2;
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    // downstream ready pattern
    initial begin
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = lfsr[0] | lfsr[1];
                default: out_ready = lfsr[0] & lfsr[3];
            endcase
        end
    end

    // output monitor
    logic          stalled = 1'b0;
    logic [OW+1:0] held;
    always @(negedge clk) begin
        #0.2;
        if (rst_n) begin
            logic [OW+2:0] e;
            if (stalled)
                check("R6 hold", {out_valid, out_eop, out_sop, out_data}, {1'b1, held});
            stalled = out_valid && !out_ready;
            held    = {out_eop, out_sop, out_data};
            if (tail_pending && !(out_valid && out_ready && out_eop))
                check("R7 input closed", in_ready, 0);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check("R6 no extra word", 1, 0);
                end else begin
                    e = expq.pop_front();
                    if (e[OW+2])
                        check((P == 1) ? "R4 serial tail" : "R5 packed tail", out_data, e[OW-1:0]);
                    else
                        check((P == 1) ? "R1 R3 data" : "R2 R3 data", out_data, e[OW-1:0]);
                    check("R8 markers", {out_eop, out_sop}, e[OW+1:OW]);
                end
                if (out_eop) tail_pending = 1'b0;
            end
        end
    end

    initial begin
        done     = 1'b0;
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        in_sys   = '0;
        in_ilv   = '0;
        wait (rst_n);
        @(negedge clk); #0.2;
        check("R9 reset state", {out_valid, in_ready}, 2'b01);
        for (int mode = 0; mode < 3; mode++)
            for (int m = 1; m <= 5; m++)
                if (m != 4)
                    for (int pat = 0; pat < 4; pat++)
                        send_block(m * P, pat, mode);
        rdy_mode = 0;
        while (expq.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check("R6 all delivered", expq.size(), 0);
        done = 1'b1;
    end
endmodule

module rsc_pair_packer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic d1, d4, d8;
    int   c1, c4, c8, f1, f4, f8;

    rsc_lane_bench #(.P(1)) u_b1 (.clk(clk), .rst_n(rst_n), .done(d1), .n_chk(c1), .n_bad(f1));
    rsc_lane_bench #(.P(4)) u_b4 (.clk(clk), .rst_n(rst_n), .done(d4), .n_chk(c4), .n_bad(f4));
    rsc_lane_bench #(.P(8)) u_b8 (.clk(clk), .rst_n(rst_n), .done(d8), .n_chk(c8), .n_bad(f8));

    initial begin
        int cyc;
        int wd;
        cyc = 0;
        wd  = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        while (!(d1 && d4 && d8) && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!(d1 && d4 && d8)) begin
            wd = 1;
            $display("FAIL watchdog: actual=running expected=done");
        end
        $display("  [TB] %0d tests run, %0d failed", c1 + c4 + c8 + wd, f1 + f4 + f8 + wd);
        $finish;
    end
endmodule